// File: doc/BRIEF.md
# Addressable Variable-Length Shift Register

This block is a single-bit serial delay line. Its storage is a chain of flip-flops whose depth is fixed by a parameter. A binary tap address picks which stage drives the output, so the delay from the serial input to the output is the address value plus one clock. The address can be held steady to give a fixed delay. It can also be changed on any cycle to give a delay that changes at run time, and the stored bits are not touched when it does.

A clock enable gates the shifting. When the enable is low, the contents hold and the output still follows the address with no clock. The block has no reset input. Its stages power up from a parameter word, one bit per stage, and that word defaults to zero.

A typical use is a small programmable pipeline delay for a control or data bit. Another is a short pattern generator that is preloaded through the initial word.

Top module: `tap_delay_line`

## Requirements
- R1: The storage is always DEPTH stages. The output `serOut` is the stored bit at stage `tapSel`. A bit shifted in appears at the output after exactly `tapSel`+1 enabled rising edges.
- R2: Address 0 gives a one-stage delay, so the output equals the bit captured at the latest enabled edge. An address of all ones gives a DEPTH-stage delay.
- R3: On each rising edge with `shiftEn` high, `serIn` enters stage 0 and every stage k moves to stage k+1. The bit in the top stage is discarded.
- R4: The output is a combinational function of the stored bits and `tapSel`. It follows an address change within the same cycle, with no clock edge needed.
- R5: While `shiftEn` is low, rising edges leave every stage unchanged. The output still tracks `tapSel`.
- R6: At start, stage i holds bit i of parameter INIT_VAL. The leftmost hex digit therefore fills the highest stages. With INIT_VAL left at its default, every stage starts at 0.
- R7: Changing `tapSel` never clears or reorders stored bits. After a length increase, the older bits already in the deeper stages are visible at once. Toggling the top address bit with all lower bits at 1 switches the delay between DEPTH and DEPTH/2.
- R8: DEPTH may be 16, 32 or 64. The address width is log2(DEPTH), which gives 4, 5 or 6 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| shiftEn | input | 1 | Clock enable; high allows a shift on the edge |
| serIn | input | 1 | Serial data into stage 0 |
| tapSel | input | log2(DEPTH) | Tap address; the delay is tapSel+1 stages |
| serOut | output | 1 | Stored bit at the addressed stage |

## Verification
The output has zero latency with respect to the address. A bit presented at an enabled edge reaches tap `a` after `a`+1 enabled edges, and a held edge moves nothing. The bench changes inputs on the falling edge and compares the output 2 ns later, before the next rising edge. At that point the output reflects only the edges already taken and the address just applied. The bench updates its reference vector only at rising edges where the enable was high. This keeps each comparison aligned with the cycle in which the result is due, for static addresses, addresses that change every cycle, held periods and the preloaded bits.

// File: rtl/tap_delay_pkg.sv
package tap_delay_pkg;

  // Strobes sent from the control module to the storage datapath.
  typedef struct packed {
    logic shiftStb;   // advance the chain on this edge
  } ctlStrobe_t;

  function automatic int addrWidth(input int depth);
    return $clog2(depth);
  endfunction

endpackage

// File: rtl/tap_delay_ctrl.sv
module tap_delay_ctrl
  import tap_delay_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = addrWidth(DEPTH)
) (
  input  logic              clk,
  input  logic              shiftEn,
  input  logic [ADDR_W-1:0] tapSel,
  output ctlStrobe_t        ctl,
  output logic [DEPTH-1:0]  tapOneHot
);

  // Shift strobe comes straight from the enable; nothing is registered here.
  always_comb begin
    ctl          = '0;
    ctl.shiftStb = shiftEn;
  end

  // Decode the binary tap address into a one-hot stage select.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_dec
    assign tapOneHot[gi] = (tapSel == ADDR_W'(gi));
  end

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R1: exactly one stage is selected for every address value.
  p_onehot_sel_r1: assert property (@(posedge clk) disable iff (!armed)
    $countones(tapOneHot) == 1);

endmodule

// File: rtl/tap_delay_store.sv
module tap_delay_store
  import tap_delay_pkg::*;
#(
  parameter int               DEPTH    = 16,
  parameter logic [DEPTH-1:0] INIT_VAL = '0
) (
  input  logic             clk,
  input  ctlStrobe_t       ctl,
  input  logic             serIn,
  input  logic [DEPTH-1:0] tapOneHot,
  output logic             tapOut
);

  // Storage chain. Stage i powers up with bit i of INIT_VAL.
  logic [DEPTH-1:0] stages = INIT_VAL;

  always_ff @(posedge clk) begin
    if (ctl.shiftStb) stages <= {stages[DEPTH-2:0], serIn};
  end

  // AND-OR read mux driven by the one-hot select.
  logic [DEPTH-1:0] gated;
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tap
    assign gated[gi] = stages[gi] & tapOneHot[gi];
  end
  assign tapOut = |gated;

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R3: the serial input lands in stage 0 on an enabled edge.
  p_shift_in_r3: assert property (@(posedge clk) disable iff (!armed)
    ctl.shiftStb |=> stages[0] == $past(serIn));

  // R3: every other stage takes its lower neighbour's old value.
  p_shift_up_r3: assert property (@(posedge clk) disable iff (!armed)
    ctl.shiftStb |=> stages[DEPTH-1:1] == $past(stages[DEPTH-2:0]));

  // R5: no strobe means the chain holds.
  p_hold_r5: assert property (@(posedge clk) disable iff (!armed)
    !ctl.shiftStb |=> $stable(stages));

  // R4: with contents held and select unchanged, the output is unchanged.
  p_out_steady_r4: assert property (@(posedge clk) disable iff (!armed)
    !ctl.shiftStb |=> (!$stable(tapOneHot) || $stable(tapOut)));

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line
  import tap_delay_pkg::*;
#(
  parameter int               DEPTH    = 16,
  parameter logic [DEPTH-1:0] INIT_VAL = '0,
  localparam int              ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              shiftEn,
  input  logic              serIn,
  input  logic [ADDR_W-1:0] tapSel,
  output logic              serOut
);

  ctlStrobe_t       ctl;
  logic [DEPTH-1:0] tapOneHot;

  tap_delay_ctrl #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk       (clk),
    .shiftEn   (shiftEn),
    .tapSel    (tapSel),
    .ctl       (ctl),
    .tapOneHot (tapOneHot)
  );

  tap_delay_store #(
    .DEPTH    (DEPTH),
    .INIT_VAL (INIT_VAL)
  ) u_store (
    .clk       (clk),
    .ctl       (ctl),
    .serIn     (serIn),
    .tapOneHot (tapOneHot),
    .tapOut    (serOut)
  );

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R2: with address 0 held, the output is the bit taken at the last enabled edge.
  p_unit_delay_r2: assert property (@(posedge clk) disable iff (!armed)
    (shiftEn && tapSel == '0) |=> (tapSel != '0 || serOut == $past(serIn)));

endmodule

// File: tb/tap_delay_line_tb.sv
`timescale 1ns/1ps
module tap_delay_line_tb;

  localparam int               DEPTH = 16;
  localparam int               AW    = 4;
  localparam logic [DEPTH-1:0] INIT  = 16'hA5C3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          shiftEn = 1'b0, serIn = 1'b0, serOut;
  logic [AW-1:0] tapSel = '0;

  logic          en32 = 1'b0, in32 = 1'b0, out32;
  logic [4:0]    sel32 = '0;

  tap_delay_line #(.DEPTH(DEPTH), .INIT_VAL(INIT)) u_dut (
    .clk(clk), .shiftEn(shiftEn), .serIn(serIn), .tapSel(tapSel), .serOut(serOut));

  tap_delay_line #(.DEPTH(32)) u_dut32 (
    .clk(clk), .shiftEn(en32), .serIn(in32), .tapSel(sel32), .serOut(out32));

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  logic [DEPTH-1:0] mdl = INIT;   // reference: stage i == mdl[i]
  logic [31:0]      mdl32 = '0;

  task automatic chk(input logic act, input logic exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive on the falling edge, check before the rising edge, then advance the model.
  task automatic step(input logic d, input logic en, input logic [AW-1:0] a, input string req);
    @(negedge clk);
    serIn = d; shiftEn = en; tapSel = a;
    #2 chk(serOut, mdl[a], req);
    @(posedge clk);
    if (en) mdl = {mdl[DEPTH-2:0], d};
  endtask

  task automatic t_initial;
    // R6: preloaded bits visible with no shift; R4: address sweep, no edge needed.
    @(negedge clk);
    shiftEn = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      tapSel = AW'(i);
      #1 chk(serOut, INIT[i], "R6 initial bit");
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      tapSel = AW'(i);
      #0.5 chk(serOut, INIT[i], "R4 combinational tap");
    end
  endtask

  task automatic t_static;
    // R1/R2: fixed lengths with random data.
    for (int n = 0; n < 40; n++) step(1'($urandom), 1'b1, 4'd0, "R2 unit delay");
    for (int n = 0; n < 40; n++) step(1'($urandom), 1'b1, 4'd15, "R2 full delay");
    for (int n = 0; n < 40; n++) step(1'($urandom), 1'b1, 4'd5, "R1 delay 6");
    // R3: a single marker walks one stage per enabled edge.
    for (int n = 0; n < DEPTH; n++) step(1'b0, 1'b1, 4'd0, "R3 clear");
    step(1'b1, 1'b1, 4'd0, "R3 marker in");
    for (int k = 0; k < DEPTH; k++) step(1'b0, 1'b1, AW'(k + 1 < DEPTH ? k + 1 : 0), "R3 marker walk");
  endtask

  task automatic t_hold;
    // R5: enable low freezes contents under random data and addresses.
    for (int n = 0; n < DEPTH; n++) step(1'($urandom), 1'b1, 4'd3, "R5 fill");
    for (int n = 0; n < 30; n++) step(1'($urandom), 1'b0, AW'($urandom), "R5 held");
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b0, AW'(i), "R5 contents kept");
  endtask

  task automatic t_dynamic;
    // R7: top address bit toggles with lower bits at one (16 <-> 8).
    for (int n = 0; n < DEPTH; n++) step(1'($urandom), 1'b1, 4'd7, "R7 fill");
    for (int n = 0; n < 30; n++) step(1'($urandom), 1'b1, (n % 2) ? 4'd15 : 4'd7, "R7 toggle");
    // R7: deeper bits show immediately after a length increase, enable low.
    step(1'b0, 1'b0, 4'd7, "R7 short");
    step(1'b0, 1'b0, 4'd15, "R7 long at once");
    for (int n = 0; n < 60; n++) step(1'($urandom), 1'($urandom), AW'($urandom), "R7 random");
  endtask

  task automatic t_depth32;
    // R8: 32 stages, 5-bit address, default zero init (R6).
    @(negedge clk);
    en32 = 1'b0;
    for (int i = 0; i < 32; i++) begin
      sel32 = 5'(i);
      #0.5 chk(out32, 1'b0, "R6 default zero");
    end
    for (int n = 0; n < 50; n++) begin
      @(negedge clk);
      in32 = 1'($urandom); en32 = 1'b1; sel32 = 5'($urandom);
      #2 chk(out32, mdl32[sel32], "R8 depth 32");
      @(posedge clk);
      mdl32 = {mdl32[30:0], in32};
    end
    @(negedge clk);
    en32 = 1'b0; sel32 = 5'd31;
    #2 chk(out32, mdl32[31], "R8 last stage");
  endtask

  initial begin
    t_initial();
    t_static();
    t_hold();
    t_dynamic();
    t_depth32();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule